// File: doc/BRIEF.md
# Two-Stage Bark/Bite Watchdog Timer

This peripheral guards a system against a hung processor. A single saturating counter advances on a slow tick-enable pulse and is compared against two programmable thresholds. When the count reaches the lower threshold, a level interrupt (bark) warns software, which can restart the count. If software does not respond and the count reaches the higher threshold, a sticky reset request (bite) goes out to the system reset logic.

Software reaches the block through a simple 32-bit register bus. Writes to control registers do not act at once. They are parked in shadow registers and take effect on the next slow tick. A pending flag stays set until then, so software can poll it and know that a restart or a new setting has reached the counter.

The bark interrupt can also serve as a wakeup request while the system sleeps, if software has enabled that.

Top module: `wdt_bark_bite`

## Requirements
- R1: After reset, bark_irq, wake_irq and bite_rst are 0. The count is 0, the enable register (0x08) reads 0, both thresholds (0x10 bark, 0x14 bite) read all-ones in their CNT_W low bits, and the pending register (0x24) reads 0.
- R2: A write to restart (0x04), enable (0x08), bark threshold (0x10) or bite threshold (0x14) sets bit 0 of the pending register (0x24) from the next clock. The register being written keeps reading its old value until the next tick. On that tick the write takes effect and the pending bit returns to 0.
- R3: While enabled (bit 0 of 0x08 set), the count rises by exactly one per tick and does not change between ticks. The status register (0x0C) shows the count in bits [CNT_W:1] and the bark state in bit 0.
- R4: Writing a value with bit 0 set to restart (0x04) sets the count to 0 on the next tick. Reads of 0x04 and of any offset other than 0x08, 0x0C, 0x10, 0x14 and 0x24 return 0.
- R5: bark_irq is 1 exactly while enabled with count >= bark threshold. It therefore stays set until a restart or a disable takes effect.
- R6: bite_rst rises one clock after the enabled count first reaches the bite threshold. It then stays 1 until rst_n is asserted, even across a restart or a disable.
- R7: With bit 0 of 0x08 cleared, the count holds its value across ticks, bark_irq is 0 and bite_rst does not newly assert.
- R8: The count saturates at 2^CNT_W-1 and never wraps to 0 without a restart.
- R9: wake_irq equals bark_irq AND bit 1 of 0x08 AND the suspended input.
- R10: Writing bite threshold 1 and then restart gives count 0 on the next tick. On the tick after that, bite_rst asserts one clock after that tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle slow time base enable |
| suspended | input | 1 | System is in a sleep state |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational, 0 when not reading |
| bark_irq | output | 1 | Level warning interrupt |
| wake_irq | output | 1 | Bark routed as a wakeup while suspended |
| bite_rst | output | 1 | Sticky system reset request |

## Verification
A corrupted count shows up in the status field on the very next read. It also moves the bark edge by at least one tick, so a tick-by-tick comparison against an arithmetic model catches it within one tick. A lost or stuck pending bit shows as a setting that applies one tick too early or never applies, which the read after each write and the read after the following tick expose. A bite that is not sticky, or that comes from the wrong comparison, is visible on bite_rst one clock after the threshold tick, or on the first check after a restart.

// File: rtl/wdt_bark_bite.sv
module wdt_bark_bite #(
  parameter int CNT_W = 20,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          suspended,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bark_irq,
  output logic          wake_irq,
  output logic          bite_rst
);
  localparam logic [CNT_W-1:0] CMAX     = '1;
  localparam logic [AW-1:0]    OFS_RST  = AW'(8'h04);
  localparam logic [AW-1:0]    OFS_EN   = AW'(8'h08);
  localparam logic [AW-1:0]    OFS_STS  = AW'(8'h0C);
  localparam logic [AW-1:0]    OFS_BARK = AW'(8'h10);
  localparam logic [AW-1:0]    OFS_BITE = AW'(8'h14);
  localparam logic [AW-1:0]    OFS_PEND = AW'(8'h24);

  logic [CNT_W-1:0] cnt_q, bark_thr_q, bite_thr_q, sh_bark, sh_bite;
  logic             en_q, wake_q, sh_en, sh_wake, bite_q;
  logic             pend_rst, pend_en, pend_bark, pend_bite;
  logic             wr, wr_rst, wr_en, wr_bark, wr_bite, en_nx;

  assign wr      = bus_en & bus_we;
  assign wr_rst  = wr & (bus_addr == OFS_RST) & bus_wdata[0];
  assign wr_en   = wr & (bus_addr == OFS_EN);
  assign wr_bark = wr & (bus_addr == OFS_BARK);
  assign wr_bite = wr & (bus_addr == OFS_BITE);
  assign en_nx   = (tick & pend_en) ? sh_en : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_en   <= 1'b0;
      sh_wake <= 1'b0;
      sh_bark <= CMAX;
      sh_bite <= CMAX;
    end else begin
      if (wr_en) {sh_wake, sh_en} <= bus_wdata[1:0];
      if (wr_bark) sh_bark <= bus_wdata[CNT_W-1:0];
      if (wr_bite) sh_bite <= bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_rst  <= 1'b0;
      pend_en   <= 1'b0;
      pend_bark <= 1'b0;
      pend_bite <= 1'b0;
    end else begin
      pend_rst  <= (pend_rst  & ~tick) | wr_rst;
      pend_en   <= (pend_en   & ~tick) | wr_en;
      pend_bark <= (pend_bark & ~tick) | wr_bark;
      pend_bite <= (pend_bite & ~tick) | wr_bite;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      wake_q     <= 1'b0;
      bark_thr_q <= CMAX;
      bite_thr_q <= CMAX;
      cnt_q      <= '0;
    end else if (tick) begin
      if (pend_en) {wake_q, en_q} <= {sh_wake, sh_en};
      if (pend_bark) bark_thr_q <= sh_bark;
      if (pend_bite) bite_thr_q <= sh_bite;
      if (pend_rst) cnt_q <= '0;
      else if (en_nx && cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bite_q <= 1'b0;
    else        bite_q <= bite_q | (en_q & (cnt_q >= bite_thr_q));
  end

  assign bark_irq = en_q & (cnt_q >= bark_thr_q);
  assign wake_irq = bark_irq & wake_q & suspended;
  assign bite_rst = bite_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      case (bus_addr)
        OFS_EN:   bus_rdata[1:0] = {wake_q, en_q};
        OFS_STS:  begin
          bus_rdata[CNT_W:1] = cnt_q;
          bus_rdata[0]       = bark_irq;
        end
        OFS_BARK: bus_rdata[CNT_W-1:0] = bark_thr_q;
        OFS_BITE: bus_rdata[CNT_W-1:0] = bite_thr_q;
        OFS_PEND: bus_rdata[0] = pend_rst | pend_en | pend_bark | pend_bite;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_bark_bite_chk.sv
module wdt_bark_bite_chk #(
  parameter int CNT_W = 20,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             bus_en,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [CNT_W-1:0] cnt_q,
  input logic             en_q,
  input logic             pend_rst,
  input logic             pend_bark,
  input logic             bark_irq,
  input logic             wake_irq,
  input logic             bite_rst
);
  // R6
  bite_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bite_rst |=> bite_rst);
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == {CNT_W{1'b1}}) && !pend_rst |=> (cnt_q == {CNT_W{1'b1}}));
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !bark_irq);
  // R9
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> bark_irq);
  // R2
  bark_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && bus_we && (bus_addr == AW'(8'h10)) |=> pend_bark);
  // R4
  rst_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_rst && tick |=> (cnt_q == '0));
endmodule

bind wdt_bark_bite wdt_bark_bite_chk #(.CNT_W(CNT_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .cnt_q(cnt_q), .en_q(en_q), .pend_rst(pend_rst),
  .pend_bark(pend_bark), .bark_irq(bark_irq), .wake_irq(wake_irq),
  .bite_rst(bite_rst)
);

// File: tb/sim_wdt_bark_bite.sv
module sim_wdt_bark_bite;
  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        suspended = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bark_irq, wake_irq, bite_rst;

  int nvec = 0;
  int nerr = 0;

  int m_cnt, m_bark, m_bite, m_sh_bark, m_sh_bite;
  bit m_en, m_wake, m_sh_en, m_sh_wake, m_bitten;
  bit m_p_rst, m_p_en, m_p_bark, m_p_bite;

  wdt_bark_bite #(.CNT_W(CW), .AW(8), .DW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .suspended(suspended),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bark_irq(bark_irq),
    .wake_irq(wake_irq), .bite_rst(bite_rst)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_barking();
    return m_en && (m_cnt >= m_bark);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 0; m_bark = CMAX; m_bite = CMAX; m_sh_bark = CMAX; m_sh_bite = CMAX;
    m_en = 0; m_wake = 0; m_sh_en = 0; m_sh_wake = 0; m_bitten = 0;
    m_p_rst = 0; m_p_en = 0; m_p_bark = 0; m_p_bite = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    case (a)
      8'h04: if (d[0]) m_p_rst = 1;
      8'h08: begin m_sh_en = d[0]; m_sh_wake = d[1]; m_p_en = 1; end
      8'h10: begin m_sh_bark = int'(d[CW-1:0]); m_p_bark = 1; end
      8'h14: begin m_sh_bite = int'(d[CW-1:0]); m_p_bite = 1; end
      default: ;
    endcase
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    if (m_p_en) begin m_en = m_sh_en; m_wake = m_sh_wake; end
    if (m_p_bark) m_bark = m_sh_bark;
    if (m_p_bite) m_bite = m_sh_bite;
    if (m_p_rst) m_cnt = 0;
    else if (m_en && m_cnt != CMAX) m_cnt++;
    m_p_rst = 0; m_p_en = 0; m_p_bark = 0; m_p_bite = 0;
    @(negedge clk);
    if (m_en && m_cnt >= m_bite) m_bitten = 1;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    rd(8'h0C, d);
    chk({tag, " R3 status"}, d, 32'((m_cnt << 1) | int'(m_barking())));
    chk({tag, " R5 bark_irq"}, {31'b0, bark_irq}, {31'b0, m_barking()});
    chk({tag, " R6 bite_rst"}, {31'b0, bite_rst}, {31'b0, m_bitten});
    chk({tag, " R9 wake_irq"}, {31'b0, wake_irq}, {31'b0, m_barking() & m_wake & suspended});
  endtask

  initial begin
    #(20 * 190000);
    nerr++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_reset();

    // R1 reset state
    chk("R1 bark_irq", {31'b0, bark_irq}, 32'd0);
    chk("R1 bite_rst", {31'b0, bite_rst}, 32'd0);
    chk("R1 wake_irq", {31'b0, wake_irq}, 32'd0);
    rd(8'h0C, d); chk("R1 status", d, 32'd0);
    rd(8'h08, d); chk("R1 enable", d, 32'd0);
    rd(8'h10, d); chk("R1 bark thr", d, 32'(CMAX));
    rd(8'h14, d); chk("R1 bite thr", d, 32'(CMAX));
    rd(8'h24, d); chk("R1 pending", d, 32'd0);

    // R4 write-only restart and undefined offsets
    rd(8'h04, d); chk("R4 restart read", d, 32'd0);
    for (int a = 0; a < 64; a += 4) begin
      if (a != 8'h08 && a != 8'h0C && a != 8'h10 && a != 8'h14 && a != 8'h24) begin
        rd(8'(a), d); chk("R4 undefined offset", d, 32'd0);
      end
    end

    // R2 pending behaviour
    wr(8'h10, 32'd3);
    rd(8'h24, d); chk("R2 pending set", d, 32'd1);
    rd(8'h10, d); chk("R2 old bark thr", d, 32'(CMAX));
    do_tick();
    rd(8'h24, d); chk("R2 pending clear", d, 32'd0);
    rd(8'h10, d); chk("R2 new bark thr", d, 32'd3);
    wr(8'h04, 32'd1);
    rd(8'h24, d); chk("R2 R4 restart pending", d, 32'd1);
    do_tick();
    rd(8'h24, d); chk("R2 restart applied", d, 32'd0);

    // R3 R5 R6 sweep over bark thresholds and bite gaps
    for (int b = 0; b < 6; b++) begin
      for (int g = 0; g < 4; g++) begin
        do_reset();
        wr(8'h10, 32'(b));
        wr(8'h14, 32'(b + g));
        wr(8'h08, 32'd1);
        for (int t = 0; t < b + g + 3; t++) begin
          do_tick();
          check_all("sweep");
        end
        // R6 sticky across restart and disable
        wr(8'h04, 32'd1);
        wr(8'h08, 32'd0);
        do_tick();
        check_all("R6 after restart");
        chk("R6 still set", {31'b0, bite_rst}, 32'd1);
      end
    end

    // R7 disable freezes count
    do_reset();
    wr(8'h10, 32'd2);
    wr(8'h14, 32'd200);
    wr(8'h08, 32'd1);
    for (int t = 0; t < 4; t++) do_tick();
    check_all("R7 before disable");
    wr(8'h08, 32'd0);
    for (int t = 0; t < 5; t++) begin
      do_tick();
      check_all("R7 disabled");
    end
    rd(8'h0C, d); chk("R7 count held", d, 32'(4 << 1));

    // R9 wakeup routing
    wr(8'h08, 32'd3);
    do_tick();
    suspended = 1'b0;
    check_all("R9 awake");
    suspended = 1'b1;
    check_all("R9 suspended");
    chk("R9 wake asserted", {31'b0, wake_irq}, 32'd1);
    wr(8'h08, 32'd1);
    do_tick();
    check_all("R9 wake masked");
    suspended = 1'b0;

    // R8 saturation
    do_reset();
    wr(8'h08, 32'd1);
    for (int t = 0; t < CMAX + 6; t++) begin
      do_tick();
      check_all("R8 run");
    end
    rd(8'h0C, d); chk("R8 saturated", d[CW:1], 32'(CMAX));

    // R10 forced bite
    do_reset();
    wr(8'h08, 32'd1);
    for (int t = 0; t < 3; t++) do_tick();
    wr(8'h14, 32'd1);
    wr(8'h04, 32'd1);
    do_tick();
    check_all("R10 restart tick");
    chk("R10 no bite yet", {31'b0, bite_rst}, 32'd0);
    do_tick();
    check_all("R10 next tick");
    chk("R10 bite", {31'b0, bite_rst}, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule